// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Map

This block is the register and memory front end of a 256-byte address space. A host reaches it through a byte-wide port that has a write strobe, a read command framed by start and end strobes, and a command strobe. The low 32 addresses hold a protection byte, a status byte, an EEPROM control byte and four two-byte measurement registers. Two 16-byte EEPROM blocks and a 16-byte SRAM sit higher in the map. The host never touches the nonvolatile array directly. Every EEPROM access lands in a shadow RAM, and copy and recall commands move a whole block between the shadow and the array. The array is a reset-initialised storage model inside the block.

A block can be made read-only. This takes two steps: the host writes an arm bit, then issues a lock command. A read command that starts on the high byte of a measurement pair freezes both bytes, so the low byte fetched later in the same command belongs to the same sample.

The command engine is a state machine with four states. `ST_IDLE` accepts commands. `ST_COPY` writes one byte per cycle into the array, then stays busy until the copy time runs out, and returns to `ST_IDLE`. `ST_RECALL` loads one byte per cycle from the array into the shadow RAM. It then goes to `ST_APPLY` for block 1, or back to `ST_IDLE` for block 0. `ST_APPLY` loads the protection and status defaults in a single cycle and returns to `ST_IDLE`. A lock command completes inside `ST_IDLE`.

Top module: `shadow_regmap`

## Requirements
- R1: After reset, the protection byte (address 00h), the status byte (01h) and the control byte (07h) all read 00h, and `copy_busy`, `sleep_en`, `alt_opcode` and `swap_en` are 0.
- R2: The protection byte at 00h can be read and written. The two EEPROM blocks occupy 20h-2Fh (block 0) and 30h-3Fh (block 1), and the SRAM occupies 80h-8Fh; all three read back what was written. The measurement pairs have their high byte (input bits 15:8) at 0Ch, 0Eh, 10h and 18h, with the low byte at the next address.
- R3: Every other address reads 00h, and writes to it have no effect.
- R4: `rd_start` loads the pointer from `rd_addr`. Each `rd_next` inside a read command puts the byte at the pointer on `rd_data` one cycle later and then advances the pointer by one.
- R5: Command code 01b (copy) on an unlocked block holds `copy_busy` and bit 7 of 07h at 1 for COPY_CYCLES cycles, starting the cycle after the command. During that window, host writes to EEPROM addresses are ignored.
- R6: Command code 10b (recall) reloads the shadow block from the array. Data that was copied survives a later overwrite of the shadow RAM.
- R7: Bit 6 of 07h is a writable arm bit. Command code 11b (lock) is ignored when the arm bit is 0. When the arm bit is 1, the lock command sets bit 0 (for block 0) or bit 1 (for block 1) of 07h and clears the arm bit.
- R8: In a locked block, host writes are ignored. A copy raises no busy flag, and a recall leaves the shadow RAM unchanged.
- R9: A recall of block 1 loads the protection byte from 31h's neighbour at 30h and loads status bits 5:3 from 31h. Status bit 5 drives `sleep_en`, bit 4 drives `alt_opcode` and bit 3 drives `swap_en`. Address 01h is read-only.
- R10: Reading a high measurement byte captures both bytes of that pair. Later reads of that pair within the same read command return the captured value.
- R11: A low measurement byte read without an earlier high-byte read in the same command returns the live input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_start | input | 1 | Opens a read command and loads the pointer |
| rd_addr | input | 8 | Start address of a read command |
| rd_next | input | 1 | Fetches one byte and advances the pointer |
| rd_end | input | 1 | Closes the read command |
| rd_data | output | 8 | Byte returned one cycle after `rd_next` |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 copy, 10 recall, 11 lock |
| cmd_blk | input | 1 | Target EEPROM block |
| meas_volt | input | 16 | Voltage sample (pair at 0Ch) |
| meas_curr | input | 16 | Current sample (pair at 0Eh) |
| meas_acc | input | 16 | Accumulated charge (pair at 10h) |
| meas_temp | input | 16 | Temperature sample (pair at 18h) |
| prot_reg | output | 8 | Protection byte |
| sleep_en | output | 1 | Status bit 5 |
| alt_opcode | output | 1 | Status bit 4 |
| swap_en | output | 1 | Status bit 3 |
| copy_busy | output | 1 | Copy in progress |

## Verification
A state machine stuck outside `ST_IDLE` shows up one cycle later as a high `copy_busy`, or as later commands being ignored. It also shows up as recalled data that never appears in a following read. A wrong lock or arm flag becomes visible at the next read of 07h. It also becomes visible when a write or recall to the affected block changes, or fails to change, the bytes read back a few cycles later. A missing or stale pair capture appears on the very next low-byte read, once the measurement input has changed between the two fetches.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_COPY   = 2'd1,
        OP_RECALL = 2'd2,
        OP_LOCK   = 2'd3
    } srm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_RECALL,
        ST_APPLY
    } srm_state_e;

    localparam logic [7:0] A_PROT  = 8'h00;
    localparam logic [7:0] A_STAT  = 8'h01;
    localparam logic [7:0] A_EECTL = 8'h07;

    localparam int NPAIR = 4;
    // high-byte addresses of the measurement pairs: volt, curr, acc, temp
    localparam logic [NPAIR-1:0][7:0] PAIR_ADDR = {8'h18, 8'h10, 8'h0E, 8'h0C};

    // bases must be aligned to the size of the region they start
    localparam int EEP_BASE  = 32;   // 20h
    localparam int SRAM_BASE = 128;  // 80h
endpackage

// File: rtl/srm_nv_array.sv
module srm_nv_array #(
    parameter int BLK_BYTES = 16,
    localparam int IDX_W = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             blk,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [1:0][BLK_BYTES-1:0][7:0] mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            mem[blk][idx] <= wdata;
        end
    end

    assign rdata = mem[blk][idx];
endmodule

// File: rtl/srm_pair_latch.sv
module srm_pair_latch (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        cap,
    input  logic [15:0] live,
    output logic [15:0] held,
    output logic        hold_v
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held   <= '0;
            hold_v <= 1'b0;
        end else if (clr) begin
            hold_v <= 1'b0;
        end else if (cap && !hold_v) begin
            held   <= live;
            hold_v <= 1'b1;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v && !clr |=> $stable(held) && hold_v);  // R10
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hold_v);  // R10
endmodule

// File: rtl/srm_seq.sv
module srm_seq
    import srm_pkg::*;
#(
    parameter int BLK_BYTES   = 16,
    parameter int COPY_CYCLES = 40,
    localparam int IDX_W = $clog2(BLK_BYTES),
    localparam int CNT_W = $clog2(COPY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_blk,
    input  logic             lock_arm,
    input  logic [1:0]       lock_bits,
    output logic             eec,
    output logic             busy,
    output logic             act_blk,
    output logic [IDX_W-1:0] idx,
    output logic             nv_we,
    output logic             sh_we,
    output logic             set_lock,
    output logic             apply_b1
);
    srm_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             blk_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && !lock_bits[cmd_blk]) begin
                    if (cmd_op == OP_COPY)        state_nx = ST_COPY;
                    else if (cmd_op == OP_RECALL) state_nx = ST_RECALL;
                end
            end
            ST_COPY: begin
                if (cnt == CNT_W'(COPY_CYCLES - 1)) state_nx = ST_IDLE;
            end
            ST_RECALL: begin
                if (cnt == CNT_W'(BLK_BYTES - 1)) state_nx = blk_q ? ST_APPLY : ST_IDLE;
            end
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            blk_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                cnt   <= '0;
                blk_q <= cmd_blk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        eec      = 1'b0;
        busy     = 1'b1;
        nv_we    = 1'b0;
        sh_we    = 1'b0;
        set_lock = 1'b0;
        apply_b1 = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                set_lock = cmd_valid && (cmd_op == OP_LOCK) && lock_arm;
            end
            ST_COPY: begin
                eec   = 1'b1;
                nv_we = cnt < CNT_W'(BLK_BYTES);
            end
            ST_RECALL: sh_we = 1'b1;
            ST_APPLY:  apply_b1 = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign act_blk = (state == ST_IDLE) ? cmd_blk : blk_q;
    assign idx     = cnt[IDX_W-1:0];

    AST_COPY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eec) |-> $past(cmd_valid && cmd_op == OP_COPY));  // R5
    AST_COPY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eec) |-> $past(cnt) == CNT_W'(COPY_CYCLES - 1));  // R5
endmodule

// File: rtl/shadow_regmap.sv
module shadow_regmap
    import srm_pkg::*;
#(
    parameter int BLK_BYTES   = 16,
    parameter int SRAM_BYTES  = 16,
    parameter int COPY_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_start,
    input  logic [7:0]  rd_addr,
    input  logic        rd_next,
    input  logic        rd_end,
    output logic [7:0]  rd_data,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        cmd_blk,
    input  logic [15:0] meas_volt,
    input  logic [15:0] meas_curr,
    input  logic [15:0] meas_acc,
    input  logic [15:0] meas_temp,
    output logic [7:0]  prot_reg,
    output logic        sleep_en,
    output logic        alt_opcode,
    output logic        swap_en,
    output logic        copy_busy
);
    localparam int IDX_W    = $clog2(BLK_BYTES);
    localparam int SIDX_W   = $clog2(SRAM_BYTES);
    localparam int EEP_END  = EEP_BASE + 2 * BLK_BYTES;
    localparam int SRAM_END = SRAM_BASE + SRAM_BYTES;

    function automatic logic in_eep(input logic [7:0] a);
        return (int'(a) >= EEP_BASE) && (int'(a) < EEP_END);
    endfunction

    function automatic logic in_sram(input logic [7:0] a);
        return (int'(a) >= SRAM_BASE) && (int'(a) < SRAM_END);
    endfunction

    function automatic logic is_pair(input logic [7:0] a);
        logic hit;
        hit = 1'b0;
        for (int p = 0; p < NPAIR; p++) begin
            if (a == PAIR_ADDR[p] || a == PAIR_ADDR[p] + 8'd1) hit = 1'b1;
        end
        return hit;
    endfunction

    // ---------------- storage and control state ----------------
    logic [1:0][BLK_BYTES-1:0][7:0] shd;
    logic [SRAM_BYTES-1:0][7:0]     sram;
    logic [7:0]                     prot_q, stat_q;
    logic                           arm_q;
    logic [1:0]                     lock_q;

    // ---------------- command engine ----------------
    logic             eec, busy_any, act_blk, nv_we, sh_we, set_lock, apply_b1;
    logic [IDX_W-1:0] seq_idx;
    logic [7:0]       nv_rdata;

    srm_seq #(.BLK_BYTES(BLK_BYTES), .COPY_CYCLES(COPY_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .lock_arm(arm_q), .lock_bits(lock_q),
        .eec(eec), .busy(busy_any), .act_blk(act_blk), .idx(seq_idx),
        .nv_we(nv_we), .sh_we(sh_we), .set_lock(set_lock), .apply_b1(apply_b1)
    );

    srm_nv_array #(.BLK_BYTES(BLK_BYTES)) nv_i (
        .clk(clk), .rst_n(rst_n),
        .we(nv_we), .blk(act_blk), .idx(seq_idx),
        .wdata(shd[act_blk][seq_idx]), .rdata(nv_rdata)
    );

    // ---------------- read command framing ----------------
    logic       rd_act;
    logic [7:0] ptr;
    logic       fetch;
    logic       hold_clr;

    assign fetch    = rd_act && rd_next;
    assign hold_clr = rd_start || rd_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act <= 1'b0;
            ptr    <= '0;
        end else if (rd_start) begin
            rd_act <= 1'b1;
            ptr    <= rd_addr;
        end else if (rd_end) begin
            rd_act <= 1'b0;
        end else if (fetch) begin
            ptr <= ptr + 8'd1;
        end
    end

    // ---------------- measurement pair capture ----------------
    logic [NPAIR-1:0][15:0] live_w, held_w;
    logic [NPAIR-1:0]       hv_w;

    assign live_w = {meas_temp, meas_acc, meas_curr, meas_volt};

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        srm_pair_latch pl_i (
            .clk(clk), .rst_n(rst_n), .clr(hold_clr),
            .cap(fetch && ptr == PAIR_ADDR[p]),
            .live(live_w[p]), .held(held_w[p]), .hold_v(hv_w[p])
        );
    end

    // ---------------- read mux ----------------
    logic [7:0] rv;

    always_comb begin
        rv = 8'h00;
        if (ptr == A_PROT)  rv = prot_q;
        if (ptr == A_STAT)  rv = stat_q;
        if (ptr == A_EECTL) rv = {eec, arm_q, 4'b0000, lock_q};
        for (int p = 0; p < NPAIR; p++) begin
            if (ptr == PAIR_ADDR[p])
                rv = hv_w[p] ? held_w[p][15:8] : live_w[p][15:8];
            if (ptr == PAIR_ADDR[p] + 8'd1)
                rv = hv_w[p] ? held_w[p][7:0] : live_w[p][7:0];
        end
        if (in_eep(ptr))  rv = shd[ptr[IDX_W]][ptr[IDX_W-1:0]];
        if (in_sram(ptr)) rv = sram[ptr[SIDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (fetch) rd_data <= rv;
    end

    // ---------------- host writes ----------------
    logic wr_eep, wr_sram;

    assign wr_eep  = wr_en && in_eep(wr_addr) && !busy_any && !lock_q[wr_addr[IDX_W]];
    assign wr_sram = wr_en && in_sram(wr_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd <= '0;
        end else begin
            if (sh_we)  shd[act_blk][seq_idx] <= nv_rdata;
            if (wr_eep) shd[wr_addr[IDX_W]][wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       sram <= '0;
        else if (wr_sram) sram[wr_addr[SIDX_W-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
            stat_q <= '0;
            arm_q  <= 1'b0;
            lock_q <= '0;
        end else begin
            if (apply_b1) begin
                prot_q <= shd[1][0];
                stat_q <= {2'b00, shd[1][1][5:3], 3'b000};
            end else if (wr_en && wr_addr == A_PROT) begin
                prot_q <= wr_data;
            end
            if (set_lock) begin
                lock_q[act_blk] <= 1'b1;
                arm_q           <= 1'b0;
            end else if (wr_en && wr_addr == A_EECTL) begin
                arm_q <= wr_data[6];
            end
        end
    end

    assign prot_reg   = prot_q;
    assign sleep_en   = stat_q[5];
    assign alt_opcode = stat_q[4];
    assign swap_en    = stat_q[3];
    assign copy_busy  = eec;

    // ---------------- assertions ----------------
    AST_LOCK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> $past(arm_q));  // R7
    AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> !arm_q);  // R7
    AST_NV_WR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> !lock_q[act_blk]);  // R8
    for (genvar b = 0; b < 2; b++) begin : g_lockchk
        AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            $past(lock_q[b]) |-> $stable(shd[b]));  // R8
    end
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fetch && !in_eep(ptr) && !in_sram(ptr) && !is_pair(ptr) &&
        ptr != A_PROT && ptr != A_STAT && ptr != A_EECTL |=> rd_data == 8'h00);  // R3
    AST_STAT_ONLY_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(apply_b1) |-> $stable(stat_q));  // R9
endmodule

// File: tb/shadow_regmap_tb.sv
module shadow_regmap_tb_top;
    localparam int CYC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_start = 1'b0, rd_next = 1'b0, rd_end = 1'b0, cmd_valid = 1'b0, cmd_blk = 1'b0;
    logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] meas_volt = '0, meas_curr = '0, meas_acc = '0, meas_temp = '0;
    logic [7:0]  rd_data, prot_reg;
    logic        sleep_en, alt_opcode, swap_en, copy_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    shadow_regmap #(.COPY_CYCLES(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_next(rd_next), .rd_end(rd_end),
        .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .meas_volt(meas_volt), .meas_curr(meas_curr), .meas_acc(meas_acc), .meas_temp(meas_temp),
        .prot_reg(prot_reg), .sleep_en(sleep_en), .alt_opcode(alt_opcode),
        .swap_en(swap_en), .copy_busy(copy_busy)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected byte per fetch
    always @(posedge clk) begin
        if (rst_n && rd_next) begin
            #1;
            if (exp_q.size() == 0) begin
                chk("R4 unexpected fetch", 16'(rd_data), 16'hFFFF);
            end else begin
                chk(tag_q.pop_front(), 16'(rd_data), 16'(exp_q.pop_front()));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_begin(input logic [7:0] a);
        rd_start = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic rd_byte(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_next = 1'b1;
        @(negedge clk);
        rd_next = 1'b0;
    endtask

    task automatic rd_finish();
        rd_end = 1'b1;
        @(negedge clk);
        rd_end = 1'b0;
    endtask

    task automatic rd1(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_begin(a);
        rd_byte(exp, tag);
        rd_finish();
    endtask

    task automatic cmd(input logic [1:0] op, input logic blk);
        cmd_valid = 1'b1; cmd_op = op; cmd_blk = blk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 prot_reg", 16'(prot_reg), 16'h00);
        chk("R1 copy_busy", 16'(copy_busy), 16'h0);
        chk("R1 status pins", 16'({sleep_en, alt_opcode, swap_en}), 16'h0);
        rd_begin(8'h00);
        rd_byte(8'h00, "R1 prot read");
        rd_byte(8'h00, "R1 status read");
        rd_finish();
        rd1(8'h07, 8'h00, "R1 ctrl read");

        // R2 protection byte, R9 status read-only
        wr(8'h00, 8'h5A);
        wr(8'h01, 8'hFF);
        rd_begin(8'h00);
        rd_byte(8'h5A, "R2 prot rw");
        rd_byte(8'h00, "R9 status read-only");
        rd_finish();

        // R2 SRAM, R4 auto-increment, R3 reserved past SRAM end
        wr(8'h80, 8'h11);
        wr(8'h81, 8'h22);
        wr(8'h8F, 8'h33);
        rd_begin(8'h8E);
        rd_byte(8'h00, "R4 sram 8E");
        rd_byte(8'h33, "R4 sram 8F");
        rd_byte(8'h00, "R3 reserved 90");
        rd_finish();
        rd_begin(8'h80);
        rd_byte(8'h11, "R2 sram 80");
        rd_byte(8'h22, "R2 sram 81");
        rd_finish();

        // R3 reserved writes ignored
        wr(8'h40, 8'hAA);
        wr(8'h02, 8'hAA);
        rd1(8'h40, 8'h00, "R3 reserved 40");
        rd1(8'h02, 8'h00, "R3 reserved 02");
        rd1(8'h1F, 8'h00, "R3 reserved 1F");

        // R5 copy block 0
        wr(8'h20, 8'hA5);
        cmd(2'b01, 1'b0);
        chk("R5 busy first cycle", 16'(copy_busy), 16'h1);
        wr(8'h21, 8'h77);
        rd1(8'h07, 8'h80, "R5 ctrl bit7 during copy");
        repeat (CYC - 5) @(negedge clk);
        chk("R5 busy last cycle", 16'(copy_busy), 16'h1);
        @(negedge clk);
        chk("R5 busy released", 16'(copy_busy), 16'h0);
        rd_begin(8'h20);
        rd_byte(8'hA5, "R2 eep 20");
        rd_byte(8'h00, "R5 write during copy ignored");
        rd_finish();

        // R6 recall restores copied data
        wr(8'h20, 8'h00);
        wr(8'h22, 8'h5A);
        cmd(2'b10, 1'b0);
        repeat (20) @(negedge clk);
        rd_begin(8'h20);
        rd_byte(8'hA5, "R6 recall 20");
        rd_byte(8'h00, "R6 recall 21");
        rd_byte(8'h00, "R6 recall 22");
        rd_finish();
        wr(8'h22, 8'h5A);

        // R7 lock arm
        cmd(2'b11, 1'b0);
        rd1(8'h07, 8'h00, "R7 lock without arm");
        wr(8'h07, 8'h40);
        rd1(8'h07, 8'h40, "R7 arm bit");
        cmd(2'b11, 1'b0);
        rd1(8'h07, 8'h01, "R7 lock sets BL0 clears arm");

        // R8 locked block
        wr(8'h20, 8'h11);
        rd1(8'h20, 8'hA5, "R8 locked write ignored");
        cmd(2'b10, 1'b0);
        repeat (20) @(negedge clk);
        rd1(8'h22, 8'h5A, "R8 locked recall ignored");
        cmd(2'b01, 1'b0);
        chk("R8 locked copy no busy", 16'(copy_busy), 16'h0);

        // R9 block 1 defaults
        wr(8'h30, 8'h03);
        wr(8'h31, 8'h38);
        cmd(2'b01, 1'b1);
        repeat (CYC + 2) @(negedge clk);
        chk("R9 no apply on copy", 16'({sleep_en, alt_opcode, swap_en}), 16'h0);
        wr(8'h31, 8'h00);
        cmd(2'b10, 1'b1);
        repeat (20) @(negedge clk);
        chk("R9 prot_reg", 16'(prot_reg), 16'h03);
        chk("R9 status pins", 16'({sleep_en, alt_opcode, swap_en}), 16'h7);
        rd_begin(8'h00);
        rd_byte(8'h03, "R9 prot read");
        rd_byte(8'h38, "R9 status read");
        rd_finish();
        rd1(8'h31, 8'h38, "R9 shadow 31");

        wr(8'h07, 8'h40);
        cmd(2'b11, 1'b1);
        rd1(8'h07, 8'h03, "R7 lock block 1");

        // R10 / R11 pair capture
        meas_volt = 16'h1234;
        meas_curr = 16'h8001;
        meas_temp = 16'h0FA0;
        rd_begin(8'h0C);
        rd_byte(8'h12, "R10 volt high");
        meas_volt = 16'hABCD;
        meas_curr = 16'h7F02;
        rd_byte(8'h34, "R10 volt low held");
        rd_byte(8'h7F, "R10 curr high");
        meas_curr = 16'h0000;
        rd_byte(8'h02, "R10 curr low held");
        rd_finish();
        rd1(8'h0D, 8'hCD, "R11 live low byte");
        rd_begin(8'h18);
        rd_byte(8'h0F, "R2 temp high");
        rd_byte(8'hA0, "R2 temp low");
        rd_finish();

        repeat (3) @(negedge clk);
        chk("R4 all fetches returned", 16'(exp_q.size()), 16'h0);
        finish_run();
    end
endmodule